// File: doc/BRIEF.md
# Byte-Lane Asynchronous Static RAM Controller

This block is a synchronous front end for one external asynchronous static RAM that has a 16-bit data bus. The memory has a pair of chip selects of opposite polarity, an active-low write strobe, an active-low output enable, and an active-low enable for each byte lane. A client issues a single-cycle request that carries an address, write data, a read/write flag and a two-bit lane mask. The controller then runs the memory pins through a fixed sequence. It drives the shared data bus through a tristate only while it owns the bus, and it captures read data with unselected lanes forced to zero. A one-cycle completion pulse marks the end of every access.

All timing is set by cycle-count parameters. These are the address and data setup before the write strobe, the strobe width, the hold after the strobe, and the read access time. Every write ends on the rising edge of the write strobe, and the selects and write data stay in place after that edge for the hold period. This gives the memory a defined terminating edge for its data setup and hold. The block does not accept a request while an access is in progress.

Top module: `sram_byte_ctrl`

## Requirements
- R1: The write strobe (`mem_wr_n`) goes low only while `mem_sel_n` is low, `mem_sel` is high and `mem_rd_n` is high. It goes low after SETUP_CYC cycles of selection and stays low for exactly PULSE_CYC cycles.
- R2: A write ends with `mem_wr_n` rising while both selects are still active and the controller is still driving the data. Selection and drive then last exactly HOLD_CYC more cycles, after which the bus is released.
- R3: During a write, only lanes whose mask bit is 1 have their enable low: bit 0 controls `mem_lo_n` and data bits 7:0, and bit 1 controls `mem_hi_n` and data bits 15:8. Lanes with a mask bit of 0 keep their stored contents.
- R4: A read holds `mem_rd_n` low for READ_CYC cycles and captures the bus on the last of them. `rd_data` returns the selected lanes and zero in each lane whose mask bit is 0.
- R5: The controller never drives `mem_data` while `mem_rd_n` is low.
- R6: After a read, `mem_rd_n` is high for at least one cycle before the controller enables its bus drivers.
- R7: `mem_sel_n` is always the complement of `mem_sel`. Both selects change in the same cycle, with `mem_wr_n` high at deselection. When idle, both lane enables are high.
- R8: A request with mask 2'b00 changes no stored lane, and a read with mask 2'b00 returns zero.
- R9: A request is accepted only when `busy` is low. A `req_valid` that arrives while busy is ignored and produces no access.
- R10: `done` pulses for exactly one cycle with `busy` low. It appears SETUP_CYC+PULSE_CYC+HOLD_CYC clock edges after the accepting edge for a write, and READ_CYC edges after it for a read.
- R11: After reset, all memory controls are inactive, `busy` and `done` are low, and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 = low byte, bit 1 = high byte |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Captured read data, unselected lanes zero |
| mem_addr | output | ADDR_W | Memory address |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_rd_n | output | 1 | Active-low output enable |
| mem_hi_n | output | 1 | Active-low enable, bits 15:8 |
| mem_lo_n | output | 1 | Active-low enable, bits 7:0 |
| mem_data | inout | 16 | Bidirectional data bus |

## Verification
The case hardest to reach from the ports is a write that begins in the first idle cycle after a read. In that situation the turnaround cycle is the only thing that keeps the two drivers apart. The bench chains accesses so that each new request is presented in the same cycle as the previous `done`, which produces back-to-back read-to-write and write-to-read pairs across a full sweep of addresses and masks. A behavioural memory on the bench commits data only at the end of the qualified write window, so a wrong terminating edge or too short a hold period shows up as a wrong value on a later read.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

    localparam int DQ_W   = 16;
    localparam int LANE_W = 8;
    localparam int LANES  = DQ_W / LANE_W;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_WSETUP = 3'd1,
        ST_WPULSE = 3'd2,
        ST_WHOLD  = 3'd3,
        ST_RWAIT  = 3'd4
    } sbc_state_e;

    typedef struct packed {
        logic             sel_n;
        logic             sel;
        logic             wr_n;
        logic             rd_n;
        logic [LANES-1:0] lane_n;
        logic             drive;
    } sbc_pins_t;

    typedef struct packed {
        logic [DQ_W-1:0]  wdata;
        logic [LANES-1:0] mask;
    } sbc_req_t;

    function automatic int sbc_max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    function automatic logic is_write_state(input sbc_state_e s);
        return (s == ST_WSETUP) || (s == ST_WPULSE) || (s == ST_WHOLD);
    endfunction

endpackage

// File: rtl/sbc_seq.sv
module sbc_seq
    import sbc_pkg::*;
#(
    parameter int SETUP_CYC = 1,
    parameter int PULSE_CYC = 2,
    parameter int HOLD_CYC  = 1,
    parameter int READ_CYC  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       req_write,
    output sbc_state_e state_q,
    output logic       accept,
    output logic       cap_en,
    output logic       busy,
    output logic       done
);
    localparam int MAXC  = sbc_max4(SETUP_CYC, PULSE_CYC, HOLD_CYC, READ_CYC);
    localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;

    localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] LD_PULSE = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] LD_HOLD  = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] LD_READ  = CNT_W'(READ_CYC - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             last;

    assign last   = (cnt_q == '0);
    assign accept = (state_q == ST_IDLE) && req_valid;
    assign cap_en = (state_q == ST_RWAIT) && last;
    assign busy   = (state_q != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        state_q <= req_write ? ST_WSETUP : ST_RWAIT;
                        cnt_q   <= req_write ? LD_SETUP : LD_READ;
                    end
                end
                ST_WSETUP: begin
                    if (last) begin
                        state_q <= ST_WPULSE;
                        cnt_q   <= LD_PULSE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_WPULSE: begin
                    if (last) begin
                        state_q <= ST_WHOLD;
                        cnt_q   <= LD_HOLD;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_WHOLD, ST_RWAIT: begin
                    if (last) begin
                        state_q <= ST_IDLE;
                        done    <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/sbc_pins.sv
module sbc_pins
    import sbc_pkg::*;
(
    input  sbc_state_e       state_q,
    input  logic [LANES-1:0] mask,
    output sbc_pins_t        pins
);
    logic sel;

    assign sel = (state_q != ST_IDLE);

    always_comb begin
        pins.sel_n = ~sel;
        pins.sel   = sel;
        pins.wr_n  = (state_q != ST_WPULSE);
        pins.rd_n  = (state_q != ST_RWAIT);
        pins.drive = is_write_state(state_q);
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign pins.lane_n[i] = ~(sel & mask[i]);
    end

endmodule

// File: rtl/sbc_capture.sv
module sbc_capture
    import sbc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_en,
    input  logic [LANES-1:0] mask,
    input  logic [DQ_W-1:0]  bus_in,
    output logic [DQ_W-1:0]  rd_data
);
    logic [LANE_W-1:0] lane_q [LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                lane_q[i] <= '0;
            end else if (cap_en) begin
                lane_q[i] <= mask[i] ? bus_in[i*LANE_W +: LANE_W] : '0;
            end
        end
        assign rd_data[i*LANE_W +: LANE_W] = lane_q[i];
    end

endmodule

// File: rtl/sram_byte_ctrl.sv
module sram_byte_ctrl
    import sbc_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int SETUP_CYC = 1,
    parameter int PULSE_CYC = 2,
    parameter int HOLD_CYC  = 1,
    parameter int READ_CYC  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    input  logic [1:0]        req_mask,
    output logic              busy,
    output logic              done,
    output logic [15:0]       rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_wr_n,
    output logic              mem_rd_n,
    output logic              mem_hi_n,
    output logic              mem_lo_n,
    inout  wire  [15:0]       mem_data
);
    sbc_state_e        state_q;
    logic              accept;
    logic              cap_en;
    sbc_pins_t         pins;
    sbc_req_t          req_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            req_q  <= '0;
        end else if (accept) begin
            addr_q      <= req_addr;
            req_q.wdata <= req_wdata;
            req_q.mask  <= req_mask;
        end
    end

    sbc_seq #(
        .SETUP_CYC(SETUP_CYC),
        .PULSE_CYC(PULSE_CYC),
        .HOLD_CYC (HOLD_CYC),
        .READ_CYC (READ_CYC)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_write(req_write),
        .state_q  (state_q),
        .accept   (accept),
        .cap_en   (cap_en),
        .busy     (busy),
        .done     (done)
    );

    sbc_pins u_pins (
        .state_q(state_q),
        .mask   (req_q.mask),
        .pins   (pins)
    );

    sbc_capture u_cap (
        .clk    (clk),
        .rst    (rst),
        .cap_en (cap_en),
        .mask   (req_q.mask),
        .bus_in (mem_data),
        .rd_data(rd_data)
    );

    assign mem_addr  = addr_q;
    assign mem_sel_n = pins.sel_n;
    assign mem_sel   = pins.sel;
    assign mem_wr_n  = pins.wr_n;
    assign mem_rd_n  = pins.rd_n;
    assign mem_hi_n  = pins.lane_n[1];
    assign mem_lo_n  = pins.lane_n[0];
    assign mem_data  = pins.drive ? req_q.wdata : 16'hzzzz;

endmodule

// File: rtl/sbc_chk.sv
module sbc_chk #(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst,
    input logic              sel_n,
    input logic              sel,
    input logic              wr_n,
    input logic              rd_n,
    input logic              hi_n,
    input logic              lo_n,
    input logic              drive,
    input logic              busy,
    input logic              done,
    input logic [15:0]       wdata,
    input logic [ADDR_W-1:0] addr
);
    // R1: write strobe only inside a selected, output-disabled window
    a_r1_write_window: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> (!sel_n && sel && rd_n && drive));

    // R2: strobe rises first, selects and data still held on that cycle
    a_r2_strobe_first: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_n) |-> (!sel_n && sel && drive));

    // R2: address and data steady across the strobe
    a_r2_data_steady: assert property (@(posedge clk) disable iff (rst)
        (!wr_n && !$past(wr_n)) |-> ($stable(wdata) && $stable(addr)));

    // R5: no bus drive while the memory output is enabled
    a_r5_no_contention: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !drive);

    // R6: output enable high in the cycle before drivers turn on
    a_r6_turnaround: assert property (@(posedge clk) disable iff (rst)
        $rose(drive) |-> $past(rd_n));

    // R7: selects complementary, deselect with write strobe high
    a_r7_sel_pair: assert property (@(posedge clk) disable iff (rst)
        sel_n == !sel);
    a_r7_deselect: assert property (@(posedge clk) disable iff (rst)
        $rose(sel_n) |-> (wr_n && hi_n && lo_n));

    // R10: single-cycle done while idle
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

endmodule

bind sram_byte_ctrl sbc_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .sel_n(mem_sel_n),
    .sel  (mem_sel),
    .wr_n (mem_wr_n),
    .rd_n (mem_rd_n),
    .hi_n (mem_hi_n),
    .lo_n (mem_lo_n),
    .drive(pins.drive),
    .busy (busy),
    .done (done),
    .wdata(req_q.wdata),
    .addr (addr_q)
);

// File: tb/sim_sram_byte_ctrl.sv
module sim_sram_byte_ctrl;

    localparam int AW = 4;
    localparam int S  = 2;
    localparam int P  = 2;
    localparam int H  = 1;
    localparam int RD = 3;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr  = '0;
    logic [15:0]   req_wdata = '0;
    logic [1:0]    req_mask  = '0;
    logic          busy, done;
    logic [15:0]   rd_data;
    logic [AW-1:0] mem_addr;
    logic          mem_sel_n, mem_sel, mem_wr_n, mem_rd_n, mem_hi_n, mem_lo_n;
    wire  [15:0]   mem_data;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sram_byte_ctrl #(
        .ADDR_W(AW), .SETUP_CYC(S), .PULSE_CYC(P), .HOLD_CYC(H), .READ_CYC(RD)
    ) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .busy(busy), .done(done), .rd_data(rd_data), .mem_addr(mem_addr),
        .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_wr_n(mem_wr_n),
        .mem_rd_n(mem_rd_n), .mem_hi_n(mem_hi_n), .mem_lo_n(mem_lo_n),
        .mem_data(mem_data)
    );

    // ---------------- behavioural memory ----------------
    logic [15:0] mem    [WORDS];
    logic [15:0] shadow [WORDS];
    wire chip_on = !mem_sel_n && mem_sel;
    wire rd_on   = chip_on && mem_wr_n && !mem_rd_n;
    wire wr_act  = chip_on && !mem_wr_n && (!mem_hi_n || !mem_lo_n);

    assign mem_data[7:0]  = (rd_on && !mem_lo_n) ? mem[mem_addr][7:0]  : 8'hzz;
    assign mem_data[15:8] = (rd_on && !mem_hi_n) ? mem[mem_addr][15:8] : 8'hzz;

    logic [AW-1:0] lat_a;
    logic [15:0]   lat_d;
    logic          lat_hi, lat_lo;

    always @(posedge clk) begin
        if (wr_act) begin
            lat_a  = mem_addr;
            lat_d  = mem_data;
            lat_hi = !mem_hi_n;
            lat_lo = !mem_lo_n;
        end
    end

    always @(negedge wr_act) begin
        if (lat_lo) mem[lat_a][7:0]  = lat_d[7:0];
        if (lat_hi) mem[lat_a][15:8] = lat_d[15:8];
    end

    // ---------------- port-level pin monitor ----------------
    logic prev_wr_n = 1'b1;
    int   low_cnt  = 0;
    int   hold_cnt = 0;
    logic in_hold  = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (mem_sel_n != !mem_sel) begin
                errors++;
                $display("FAIL R7 selects not complementary: sel_n=%b sel=%b exp sel_n=%b", mem_sel_n, mem_sel, !mem_sel);
            end
            if (!mem_wr_n && !(chip_on && mem_rd_n)) begin
                errors++;
                $display("FAIL R1 strobe outside window: sel_n=%b sel=%b rd_n=%b exp 0 1 1", mem_sel_n, mem_sel, mem_rd_n);
            end
            if (!mem_wr_n) low_cnt++;
            if (in_hold) begin
                if (chip_on) hold_cnt++;
                else begin
                    in_hold = 1'b0;
                    checks++;
                    if (hold_cnt != H || !mem_wr_n) begin
                        errors++;
                        $display("FAIL R2 hold cycles: act=%0d exp=%0d (wr_n=%b at deselect, R7)", hold_cnt, H, mem_wr_n);
                    end
                end
            end
            if (!prev_wr_n && mem_wr_n) begin
                checks++;
                if (!chip_on || low_cnt != P) begin
                    errors++;
                    $display("FAIL R1/R2 strobe end: pulse=%0d exp=%0d chip_on=%b exp 1", low_cnt, P, chip_on);
                end
                low_cnt  = 0;
                in_hold  = 1'b1;
                hold_cnt = 1;
            end
            prev_wr_n = mem_wr_n;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] lane_sel(input logic [15:0] d, input logic [1:0] m);
        return {m[1] ? d[15:8] : 8'h00, m[0] ? d[7:0] : 8'h00};
    endfunction

    // chain=1: called at the negedge where done was seen, request issued there
    task automatic access(input logic wr, input logic [AW-1:0] a, input logic [15:0] d,
                          input logic [1:0] m, input logic chain, input logic intrude);
        int lat;
        if (!chain) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        @(posedge clk);
        lat = 0;
        @(negedge clk);
        req_valid = 1'b0;
        // R9: request while busy must be ignored
        if (intrude) begin
            req_valid = 1'b1; req_write = 1'b1; req_addr = a ^ 1'b1;
            req_wdata = 16'hDEAD; req_mask = 2'b11;
            @(posedge clk); lat++; @(negedge clk);
            req_valid = 1'b0;
        end
        chk(busy, "R9 busy during access", {31'd0, busy}, 32'd1);
        while (!done && lat < 100) begin
            @(posedge clk); lat++; @(negedge clk);
        end
        chk(lat == (wr ? S + P + H : RD), wr ? "R10 write latency" : "R10 read latency", lat, wr ? S + P + H : RD);
        chk(!busy, "R10 busy low with done", {31'd0, busy}, 32'd0);
        if (wr) begin
            if (m[0]) shadow[a][7:0]  = d[7:0];
            if (m[1]) shadow[a][15:8] = d[15:8];
        end else begin
            chk(rd_data == lane_sel(shadow[a], m), m == 2'b00 ? "R8 empty-mask read" : "R4 read lanes",
                {16'd0, rd_data}, {16'd0, lane_sel(shadow[a], m)});
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
        $finish;
    end

    // ---------------- main ----------------
    initial begin
        for (int i = 0; i < WORDS; i++) begin
            mem[i]    = 16'(i * 16'h0F1D) ^ 16'h3C5A;
            shadow[i] = 16'(i * 16'h0F1D) ^ 16'h3C5A;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        chk(mem_sel_n && !mem_sel && mem_wr_n && mem_rd_n && mem_hi_n && mem_lo_n,
            "R11 pins idle in reset", {26'd0, mem_sel_n, mem_sel, mem_wr_n, mem_rd_n, mem_hi_n, mem_lo_n}, 32'h2F);
        chk(!busy && !done, "R11 busy/done low", {30'd0, busy, done}, 32'd0);
        chk(rd_data == 16'h0, "R11 rd_data zero", {16'd0, rd_data}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(mem_hi_n && mem_lo_n && mem_sel_n, "R7 idle lanes off", {29'd0, mem_hi_n, mem_lo_n, mem_sel_n}, 32'd7);

        // R4 initial content, every address, every mask
        for (int a = 0; a < WORDS; a++)
            for (int m = 0; m < 4; m++)
                access(1'b0, AW'(a), 16'h0, 2'(m), 1'b0, 1'b0);

        // R3/R8 sweep: write each mask, chain reads straight after (R6 pairs)
        for (int a = 0; a < WORDS; a++) begin
            for (int m = 0; m < 4; m++) begin
                access(1'b1, AW'(a), 16'(a * 16'h1357 + m * 16'h0B0B) ^ 16'hA55A, 2'(m), 1'b0, 1'b0);
                access(1'b0, AW'(a), 16'h0, 2'b11, 1'b1, 1'b0);
                access(1'b1, AW'((a + 5) % WORDS), 16'(a * 16'h2468) ^ 16'h0FF0, 2'(3 - m), 1'b1, 1'b0);
                access(1'b0, AW'((a + 5) % WORDS), 16'h0, 2'(m), 1'b1, 1'b0);
            end
        end

        // R9: intruding request during a write is dropped
        access(1'b1, AW'(6), 16'h1234, 2'b11, 1'b0, 1'b1);
        repeat (3) begin
            @(posedge clk); @(negedge clk);
            chk(!busy && !done, "R9 no extra access", {30'd0, busy, done}, 32'd0);
        end
        access(1'b0, AW'(7), 16'h0, 2'b11, 1'b0, 1'b0);
        access(1'b0, AW'(6), 16'h0, 2'b11, 1'b0, 1'b0);

        // R10: done lasts one cycle
        @(posedge clk); @(negedge clk);
        chk(!done, "R10 done single cycle", {31'd0, done}, 32'd0);

        // R3/R6: final full compare via back-to-back read sweep
        access(1'b0, AW'(0), 16'h0, 2'b11, 1'b0, 1'b0);
        for (int a = 1; a < WORDS; a++)
            access(1'b0, AW'(a), 16'h0, 2'b11, 1'b1, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
        $finish;
    end

endmodule